// File: doc/BRIEF.md
# Sequential Stream Prefetch Engine

This block sits beside a data cache and listens to the cache's miss traffic. When two loads miss on neighbouring cache lines, it opens a prefetch stream that runs in the direction those two misses went, either up or down. From then on, each load that lands on the line the stream expects moves the stream one line further. Each such move also produces one prefetch request, for the line the stream now expects. A stream is dropped rather than followed across a page edge. The page size is chosen by a mode input: 4 KB for small pages, or 16 MB for large pages.

There are two tables. The candidate table keeps the line numbers of the eight most recent load misses that did not match a stream; it fills in ring order. The stream table holds up to eight streams. Each stream has a valid bit, a direction and the next expected line, and the table keeps a recency order. Every miss that is a load falls into one of four action classes, tested in this order:
- ADVANCE: the load hits a stream's expected line.
- NONE: the load repeats the line a stream has just taken, and is dropped.
- CREATE: the load pairs with a candidate one line away, and the new stream stays inside its page.
- RECORD: anything else. The line is stored as a candidate.

Stores never reach the tables.

The prefetch request leaves through a two-state machine:
- REQ_IDLE goes to REQ_HOLD when a request is issued.
- REQ_HOLD stays in REQ_HOLD while `pf_ready` is low.
- REQ_HOLD returns to REQ_IDLE on `pf_ready` when there is no new request.
- REQ_HOLD reloads the address and stays in REQ_HOLD on `pf_ready` when a new request arrives in the same cycle.

A request that comes while REQ_HOLD is waiting is discarded. The stream it came from still advances.

Top module: `stream_prefetch_engine`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every stream and every candidate. After reset, `pf_valid` is 0 and `stream_valid` is all zeros.
- R2: A load on line L followed by a load on line L+1 opens an ascending stream: its `stream_desc` bit is 0. The next cycle, it presents a request at address (L+2)*128.
- R3: A load on line L followed by a load on line L-1 opens a descending stream: its `stream_desc` bit is 1. It presents a request at address (L-2)*128.
- R4: Stores (`acc_is_load`=0) neither create, train nor advance a stream, and they are not recorded as candidates.
- R5: A load on a stream's expected line E produces a request for E+1 (ascending) or E-1 (descending). That line becomes the new expected line.
- R6: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` and `pf_addr` stay unchanged. A request raised during that time is dropped, but its stream still advances. After acceptance with no new request, `pf_valid` returns to 0.
- R7: If the line a stream would move to lies in another page, no request is made. This applies both when a stream would be created and when it would advance. An existing stream in that case has its slot freed.
- R8: With `large_page`=0 a page is 4096 bytes; with `large_page`=1 it is 16 MB.
- R9: The line number is the access address with its 7 low bits dropped (128-byte lines). Offsets inside a line do not matter.
- R10: At most 8 streams exist. A new stream takes the lowest-numbered free slot.
- R11: When all 8 slots are in use, a new stream replaces the slot that was created or advanced least recently.
- R12: A load on the line a stream took last is ignored. It creates no stream and is not recorded as a candidate.
- R13: The candidate table keeps the last 8 recorded load lines. A ninth recorded line evicts the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| large_page | input | 1 | Page size select: 0 = 4 KB, 1 = 16 MB |
| acc_valid | input | 1 | A miss access is presented this cycle |
| acc_is_load | input | 1 | 1 = load, 0 = store |
| acc_addr | input | 32 | Physical byte address of the access |
| pf_ready | input | 1 | The downstream side accepts the prefetch request |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_addr | output | 32 | Line-aligned address of the prefetch request |
| stream_valid | output | 8 | One bit per stream slot: the slot holds a live stream |
| stream_desc | output | 8 | One bit per live slot: 1 = descending |

## Verification
The hold property assumes that the downstream side lowers `pf_ready` only as a stall, and never withdraws it in the same cycle it sees a new request. The bench changes `pf_ready` only one time unit after a clock edge, and only between accesses. The property that stores leave the stream status alone assumes that a single access is presented per cycle. The bench's access task drives one access and then leaves the cycle after it idle. Each scenario uses its own page-aligned address region, and reset is applied between scenarios. As a result, no candidate left over from an earlier scenario can pair with a later miss. This keeps the expected request queue exact.

// File: rtl/spe_pkg.sv
package spe_pkg;

    typedef enum logic {
        REQ_IDLE,
        REQ_HOLD
    } req_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_RECORD,
        ACT_CREATE,
        ACT_ADVANCE
    } miss_act_e;

endpackage

// File: rtl/spe_cand_table.sv
module spe_cand_table #(
    parameter int NUM_CAND = 8,
    parameter int LINE_W   = 25,
    localparam int CIDX_W  = $clog2(NUM_CAND)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] look_line,
    output logic              up_hit,
    output logic [CIDX_W-1:0] up_idx,
    output logic              dn_hit,
    output logic [CIDX_W-1:0] dn_idx,
    input  logic              ins_en,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              clr_en,
    input  logic [CIDX_W-1:0] clr_idx
);

    logic [LINE_W-1:0]   line_q [NUM_CAND];
    logic [NUM_CAND-1:0] vld_q;
    logic [CIDX_W-1:0]   ptr_q;

    logic [LINE_W-1:0] below_line;
    logic [LINE_W-1:0] above_line;

    assign below_line = look_line - LINE_W'(1);
    assign above_line = look_line + LINE_W'(1);

    // lookup: lowest index wins for each direction
    always_comb begin
        up_hit = 1'b0;
        up_idx = '0;
        dn_hit = 1'b0;
        dn_idx = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
            if (!up_hit && vld_q[i] && (line_q[i] == below_line)) begin
                up_hit = 1'b1;
                up_idx = CIDX_W'(i);
            end
            if (!dn_hit && vld_q[i] && (line_q[i] == above_line)) begin
                dn_hit = 1'b1;
                dn_idx = CIDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            if (clr_en) begin
                vld_q[clr_idx] <= 1'b0;
            end
            if (ins_en) begin
                vld_q[ptr_q] <= 1'b1;
                ptr_q <= (ptr_q == CIDX_W'(NUM_CAND - 1)) ? '0 : ptr_q + CIDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            line_q[ptr_q] <= ins_line;
        end
    end

    // R13: a recorded line lands in the ring slot the pointer named
    assert_record_lands_R13: assert property (@(posedge clk) disable iff (rst)
        ins_en |=> (vld_q[$past(ptr_q)] && (line_q[$past(ptr_q)] == $past(ins_line))));

endmodule

// File: rtl/spe_stream_table.sv
module spe_stream_table #(
    parameter int NUM_STREAMS = 8,
    parameter int LINE_W      = 25,
    localparam int SIDX_W     = $clog2(NUM_STREAMS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LINE_W-1:0]      look_line,
    output logic                   hit,
    output logic [SIDX_W-1:0]      hit_idx,
    output logic                   hit_desc,
    output logic                   dup,
    input  logic                   adv_en,
    input  logic [SIDX_W-1:0]      adv_idx,
    input  logic                   adv_kill,
    input  logic [LINE_W-1:0]      adv_next,
    input  logic                   alloc_en,
    input  logic [LINE_W-1:0]      alloc_next,
    input  logic                   alloc_desc,
    output logic [SIDX_W-1:0]      alloc_idx,
    output logic [NUM_STREAMS-1:0] valid_o,
    output logic [NUM_STREAMS-1:0] desc_o
);

    localparam logic [SIDX_W-1:0] RANK_TOP = SIDX_W'(NUM_STREAMS - 1);

    logic [LINE_W-1:0]      next_q [NUM_STREAMS];
    logic [SIDX_W-1:0]      rank_q [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] vld_q;
    logic [NUM_STREAMS-1:0] desc_q;

    logic [NUM_STREAMS-1:0] rank_zero;
    logic                   free_found;
    logic [SIDX_W-1:0]      free_idx;
    logic [SIDX_W-1:0]      victim_idx;
    logic                   touch_en;
    logic [SIDX_W-1:0]      touch_idx;

    // expected-line match and repeat-of-last-line detection
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        hit_desc = 1'b0;
        dup      = 1'b0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (!hit && vld_q[i] && (next_q[i] == look_line)) begin
                hit      = 1'b1;
                hit_idx  = SIDX_W'(i);
                hit_desc = desc_q[i];
            end
            if (vld_q[i] && (look_line == (desc_q[i] ? next_q[i] + LINE_W'(1)
                                                      : next_q[i] - LINE_W'(1)))) begin
                dup = 1'b1;
            end
        end
    end

    // slot choice: lowest free slot, else the least recently touched
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        victim_idx = '0;
        rank_zero  = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            rank_zero[i] = (rank_q[i] == '0);
            if (!free_found && !vld_q[i]) begin
                free_found = 1'b1;
                free_idx   = SIDX_W'(i);
            end
            if (rank_q[i] == '0) begin
                victim_idx = SIDX_W'(i);
            end
        end
        alloc_idx = free_found ? free_idx : victim_idx;
    end

    assign touch_en  = alloc_en || (adv_en && !adv_kill);
    assign touch_idx = alloc_en ? alloc_idx : adv_idx;

    // recency ranks: a permutation, top rank = most recently touched
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                rank_q[i] <= SIDX_W'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                if (SIDX_W'(i) == touch_idx) begin
                    rank_q[i] <= RANK_TOP;
                end else if (rank_q[i] > rank_q[touch_idx]) begin
                    rank_q[i] <= rank_q[i] - SIDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (alloc_en) begin
            vld_q[alloc_idx] <= 1'b1;
        end else if (adv_en && adv_kill) begin
            vld_q[adv_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            next_q[alloc_idx] <= alloc_next;
            desc_q[alloc_idx] <= alloc_desc;
        end else if (adv_en && !adv_kill) begin
            next_q[adv_idx] <= adv_next;
        end
    end

    assign valid_o = vld_q;
    assign desc_o  = desc_q & vld_q;

    // R11: exactly one slot holds the lowest recency rank
    assert_single_victim_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(rank_zero) == 1);

    // R10: a new stream goes into a free slot while one exists
    assert_free_first_R10: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && !(&vld_q)) |-> !vld_q[alloc_idx]);

    // R10: the chosen slot is live after creation
    assert_alloc_live_R10: assert property (@(posedge clk) disable iff (rst)
        alloc_en |=> vld_q[$past(alloc_idx)]);

    // R7: a stream stopped at a page edge gives up its slot
    assert_edge_frees_R7: assert property (@(posedge clk) disable iff (rst)
        (adv_en && adv_kill) |=> !vld_q[$past(adv_idx)]);

endmodule

// File: rtl/spe_req_fsm.sv
module spe_req_fsm
    import spe_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 7,
    localparam int LINE_W   = ADDR_W - LINE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_en,
    input  logic [LINE_W-1:0] issue_line,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    req_state_e state_q;
    req_state_e state_d;
    logic       load_addr;

    always_comb begin
        state_d   = state_q;
        load_addr = 1'b0;
        unique case (state_q)
            REQ_IDLE: begin
                if (issue_en) begin
                    state_d   = REQ_HOLD;
                    load_addr = 1'b1;
                end
            end
            REQ_HOLD: begin
                if (pf_ready) begin
                    if (issue_en) begin
                        state_d   = REQ_HOLD;
                        load_addr = 1'b1;
                    end else begin
                        state_d = REQ_IDLE;
                    end
                end
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pf_valid = (state_q == REQ_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_addr <= '0;
        end else if (load_addr) begin
            pf_addr <= {issue_line, LINE_BITS'(0)};
        end
    end

    // R6: a stalled request keeps its address until taken
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

endmodule

// File: rtl/stream_prefetch_engine.sv
module stream_prefetch_engine
    import spe_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int LINE_BITS       = 7,
    parameter int NUM_STREAMS     = 8,
    parameter int NUM_CAND        = 8,
    parameter int SMALL_PAGE_BITS = 12,
    parameter int LARGE_PAGE_BITS = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   large_page,
    input  logic                   acc_valid,
    input  logic                   acc_is_load,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   pf_ready,
    output logic                   pf_valid,
    output logic [ADDR_W-1:0]      pf_addr,
    output logic [NUM_STREAMS-1:0] stream_valid,
    output logic [NUM_STREAMS-1:0] stream_desc
);

    localparam int LINE_W   = ADDR_W - LINE_BITS;
    localparam int SIDX_W   = $clog2(NUM_STREAMS);
    localparam int CIDX_W   = $clog2(NUM_CAND);
    localparam int SMALL_SH = SMALL_PAGE_BITS - LINE_BITS;
    localparam int LARGE_SH = LARGE_PAGE_BITS - LINE_BITS;

    logic [LINE_W-1:0] acc_line;
    logic [LINE_W-1:0] page_mask;
    logic              is_ld;

    logic              st_hit;
    logic [SIDX_W-1:0] st_hit_idx;
    logic              st_hit_desc;
    logic              st_dup;
    logic [SIDX_W-1:0] st_alloc_idx;

    logic              c_up_hit;
    logic [CIDX_W-1:0] c_up_idx;
    logic              c_dn_hit;
    logic [CIDX_W-1:0] c_dn_idx;

    miss_act_e         act;
    logic              step_desc;
    logic [LINE_W-1:0] step_line;
    logic              step_cross;
    logic              issue_en;

    assign acc_line  = acc_addr[ADDR_W-1:LINE_BITS];
    assign is_ld     = acc_valid && acc_is_load;
    assign page_mask = large_page ? ({LINE_W{1'b1}} << LARGE_SH)
                                  : ({LINE_W{1'b1}} << SMALL_SH);

    // direction of the step: the stream's own, or the pairing's
    assign step_desc  = st_hit ? st_hit_desc : !c_up_hit;
    assign step_line  = step_desc ? acc_line - LINE_W'(1) : acc_line + LINE_W'(1);
    assign step_cross = |((acc_line ^ step_line) & page_mask);

    always_comb begin
        act = ACT_NONE;
        if (is_ld) begin
            if (st_hit) begin
                act = ACT_ADVANCE;
            end else if (st_dup) begin
                act = ACT_NONE;
            end else if ((c_up_hit || c_dn_hit) && !step_cross) begin
                act = ACT_CREATE;
            end else begin
                act = ACT_RECORD;
            end
        end
    end

    assign issue_en = (act == ACT_CREATE) || ((act == ACT_ADVANCE) && !step_cross);

    spe_cand_table #(
        .NUM_CAND (NUM_CAND),
        .LINE_W   (LINE_W)
    ) u_cand (
        .clk       (clk),
        .rst       (rst),
        .look_line (acc_line),
        .up_hit    (c_up_hit),
        .up_idx    (c_up_idx),
        .dn_hit    (c_dn_hit),
        .dn_idx    (c_dn_idx),
        .ins_en    (act == ACT_RECORD),
        .ins_line  (acc_line),
        .clr_en    (act == ACT_CREATE),
        .clr_idx   (c_up_hit ? c_up_idx : c_dn_idx)
    );

    spe_stream_table #(
        .NUM_STREAMS (NUM_STREAMS),
        .LINE_W      (LINE_W)
    ) u_streams (
        .clk        (clk),
        .rst        (rst),
        .look_line  (acc_line),
        .hit        (st_hit),
        .hit_idx    (st_hit_idx),
        .hit_desc   (st_hit_desc),
        .dup        (st_dup),
        .adv_en     (act == ACT_ADVANCE),
        .adv_idx    (st_hit_idx),
        .adv_kill   (step_cross),
        .adv_next   (step_line),
        .alloc_en   (act == ACT_CREATE),
        .alloc_next (step_line),
        .alloc_desc (step_desc),
        .alloc_idx  (st_alloc_idx),
        .valid_o    (stream_valid),
        .desc_o     (stream_desc)
    );

    spe_req_fsm #(
        .ADDR_W    (ADDR_W),
        .LINE_BITS (LINE_BITS)
    ) u_req (
        .clk        (clk),
        .rst        (rst),
        .issue_en   (issue_en),
        .issue_line (step_line),
        .pf_ready   (pf_ready),
        .pf_valid   (pf_valid),
        .pf_addr    (pf_addr)
    );

    // R4: a store leaves the stream status untouched
    assert_store_inert_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_is_load) |=> ($stable(stream_valid) && $stable(stream_desc)));

    // R2: a load that pairs with a candidate inside one page yields a request
    assert_pair_requests_R2: assert property (@(posedge clk) disable iff (rst)
        (is_ld && !st_hit && !st_dup && (c_up_hit || c_dn_hit) && !step_cross)
        |=> pf_valid);

endmodule

// File: tb/stream_prefetch_engine_tb.sv
`timescale 1ns/1ps
module stream_prefetch_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        large_page = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_is_load = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        pf_ready = 1'b1;
    logic        pf_valid;
    logic [31:0] pf_addr;
    logic [7:0]  stream_valid;
    logic [7:0]  stream_desc;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    always #2.5 clk = ~clk;

    stream_prefetch_engine u_dut (
        .clk          (clk),
        .rst          (rst),
        .large_page   (large_page),
        .acc_valid    (acc_valid),
        .acc_is_load  (acc_is_load),
        .acc_addr     (acc_addr),
        .pf_ready     (pf_ready),
        .pf_valid     (pf_valid),
        .pf_addr      (pf_addr),
        .stream_valid (stream_valid),
        .stream_desc  (stream_desc)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        exp_q.delete();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic access(input logic ld, input logic [31:0] addr);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_is_load = ld; acc_addr = addr;
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic expect_req(input logic [31:0] addr);
        exp_q.push_back(addr);
    endtask

    task automatic drain(input string tag);
        repeat (4) @(posedge clk);
        #1 check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
    endtask

    // scoreboard monitor: compares every accepted request with the queue
    always @(negedge clk) begin
        if (!rst && pf_valid && pf_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected request R4 R7 R12", pf_addr, 32'd0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(pf_addr == e, "request address R2 R3 R5", pf_addr, e);
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check(pf_valid == 1'b0, "R1 pf_valid after reset", 32'(pf_valid), 32'd0);
        check(stream_valid == 8'h00, "R1 streams after reset", 32'(stream_valid), 32'd0);

        // R2, R9, R5: ascending stream, offsets inside a line ignored
        expect_req(32'h0001_0100);
        access(1'b1, 32'h0001_0010);
        access(1'b1, 32'h0001_00FF);
        check(stream_valid == 8'h01, "R2 stream opened", 32'(stream_valid), 32'h01);
        check(stream_desc == 8'h00, "R2 ascending", 32'(stream_desc), 32'h00);
        expect_req(32'h0001_0180);
        access(1'b1, 32'h0001_0100);
        expect_req(32'h0001_0200);
        access(1'b1, 32'h0001_0184);
        drain("R5 R9 ascending requests");

        // R3: descending stream
        do_reset();
        expect_req(32'h0002_0300);
        access(1'b1, 32'h0002_0400);
        access(1'b1, 32'h0002_0380);
        check(stream_desc == 8'h01, "R3 descending flag", 32'(stream_desc), 32'h01);
        expect_req(32'h0002_0280);
        access(1'b1, 32'h0002_0300);
        drain("R3 descending requests");

        // R4: stores are ignored
        do_reset();
        access(1'b0, 32'h0003_0000);
        access(1'b0, 32'h0003_0080);
        check(stream_valid == 8'h00, "R4 store pair", 32'(stream_valid), 32'h00);
        access(1'b1, 32'h0003_0000);
        access(1'b0, 32'h0003_0080);
        check(stream_valid == 8'h00, "R4 load then store", 32'(stream_valid), 32'h00);
        expect_req(32'h0003_0100);
        access(1'b1, 32'h0003_0080);
        check(stream_valid == 8'h01, "R4 load pair after stores", 32'(stream_valid), 32'h01);
        drain("R4 requests");

        // R7, R8: small page boundary
        do_reset();
        large_page = 1'b0;
        access(1'b1, 32'h0004_0F00);
        access(1'b1, 32'h0004_0F80);
        check(stream_valid == 8'h00, "R7 no stream across page", 32'(stream_valid), 32'h00);
        expect_req(32'h0005_0F80);
        access(1'b1, 32'h0005_0E80);
        access(1'b1, 32'h0005_0F00);
        check(stream_valid == 8'h01, "R7 stream inside page", 32'(stream_valid), 32'h01);
        access(1'b1, 32'h0005_0F80);
        check(stream_valid == 8'h00, "R7 slot freed at edge", 32'(stream_valid), 32'h00);
        drain("R7 requests");

        // R8: large pages let a stream pass a 4 KB edge, stop at 16 MB
        do_reset();
        large_page = 1'b1;
        expect_req(32'h0006_1000);
        access(1'b1, 32'h0006_0F00);
        access(1'b1, 32'h0006_0F80);
        expect_req(32'h0006_1080);
        access(1'b1, 32'h0006_1000);
        access(1'b1, 32'h00FF_FF00);
        access(1'b1, 32'h00FF_FF80);
        check(stream_valid == 8'h01, "R8 large page edge", 32'(stream_valid), 32'h01);
        drain("R8 requests");
        large_page = 1'b0;

        // R6: held request, dropped request, release
        do_reset();
        pf_ready = 1'b0;
        access(1'b1, 32'h0007_0000);
        access(1'b1, 32'h0007_0080);
        repeat (3) @(posedge clk);
        #1 check(pf_valid == 1'b1, "R6 held valid", 32'(pf_valid), 32'd1);
        check(pf_addr == 32'h0007_0100, "R6 held address", pf_addr, 32'h0007_0100);
        access(1'b1, 32'h0007_0100);
        check(pf_addr == 32'h0007_0100, "R6 address kept over new advance", pf_addr, 32'h0007_0100);
        expect_req(32'h0007_0100);
        pf_ready = 1'b1;
        repeat (2) @(posedge clk);
        #1 check(pf_valid == 1'b0, "R6 valid drops after accept", 32'(pf_valid), 32'd0);
        expect_req(32'h0007_0200);
        access(1'b1, 32'h0007_0180);
        drain("R6 requests");

        // R10, R11: fill all slots, then replace the least recent
        do_reset();
        for (int k = 0; k < 8; k++) begin
            logic [31:0] b;
            b = 32'h0010_0000 * 32'(k + 1);
            expect_req(b + 32'h100);
            access(1'b1, b);
            access(1'b1, b + 32'h80);
            check(stream_valid == 8'((16'h1 << (k + 1)) - 1), "R10 lowest free slot",
                  32'(stream_valid), 32'((16'h1 << (k + 1)) - 1));
        end
        expect_req(32'h0010_0180);
        access(1'b1, 32'h0010_0100);
        expect_req(32'h0090_0000);
        access(1'b1, 32'h0090_0100);
        access(1'b1, 32'h0090_0080);
        check(stream_valid == 8'hFF, "R11 all slots live", 32'(stream_valid), 32'hFF);
        check(stream_desc == 8'h02, "R11 slot 1 replaced", 32'(stream_desc), 32'h02);
        access(1'b1, 32'h0020_0100);
        expect_req(32'h0010_0200);
        access(1'b1, 32'h0010_0180);
        drain("R11 requests");

        // R12: repeat of last line ignored
        do_reset();
        expect_req(32'h000A_0900);
        access(1'b1, 32'h000A_0800);
        access(1'b1, 32'h000A_0880);
        access(1'b1, 32'h000A_0880);
        access(1'b1, 32'h000A_0800);
        check(stream_valid == 8'h01, "R12 no duplicate stream", 32'(stream_valid), 32'h01);
        drain("R12 requests");

        // R13: candidate depth of eight
        do_reset();
        access(1'b1, 32'h000B_0000);
        for (int k = 0; k < 7; k++) access(1'b1, 32'h000C_0000 + 32'(k) * 32'h1000);
        expect_req(32'h000B_0100);
        access(1'b1, 32'h000B_0080);
        check(stream_valid == 8'h01, "R13 oldest of eight kept", 32'(stream_valid), 32'h01);
        drain("R13 requests");
        do_reset();
        access(1'b1, 32'h000B_0000);
        for (int k = 0; k < 8; k++) access(1'b1, 32'h000C_0000 + 32'(k) * 32'h1000);
        access(1'b1, 32'h000B_0080);
        check(stream_valid == 8'h00, "R13 ninth record evicts", 32'(stream_valid), 32'h00);
        drain("R13 eviction requests");

        summary();
        $finish;
    end

endmodule